// File: doc/BRIEF.md
# Six-Channel Column Code Load Sequencer

This block is the digital front end of a six-channel column driver for a video panel. One shared 10-bit bus carries pixel codes. The block steers each word into a per-channel holding register, called stage one. A transfer strobe then copies all six holding registers into the output registers, called stage two, on one clock edge. Because of this, every channel code presented to the converters changes at the same moment.

There are two ways to fill the holding registers:

- **Sequence mode.** A start pulse arms a sequence. The next six clock cycles fill the channels in ascending order, or in descending order when the panel image is mirrored. A one-cycle done pulse then tells the next device in a cascade to begin its own sequence.
- **Direct mode.** Outside a sequence, a single channel can be written by address for test or debug.

A mode pin chooses which clock edge captures the bus and control inputs. This lets two devices interleave even and odd words on one bus.

The controller has three states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting. Direct writes are allowed. |
| `ST_FILL` | One word is stored per cycle at the sequence pointer. |
| `ST_DONE` | Lasts one cycle. The done flag is high and direct writes are allowed. |

The transitions are:

- **IDLE→FILL and DONE→FILL:** taken on a captured start.
- **FILL→FILL:** restart on a captured start, or advance to the next channel while fewer than six words are stored.
- **FILL→DONE:** taken after the sixth word.
- **DONE→IDLE:** taken unconditionally.

Top module: `vidcol_loader`

## Requirements
- R1: While `rst_n` is low, every stage-one and stage-two register holds code 0 and `seq_done` is 0.
- R2: A captured `go_seq` arms a new sequence and writes no stage-one register on that edge.
- R3: In ascending mode (`dir_desc`=0 at start), the six captured words after the start go to channels 0,1,2,3,4,5 in that order. Channel i is read from `code_out[10*i+9:10*i]`.
- R4: In descending mode (`dir_desc`=1 at start), the six words go to channels 5,4,3,2,1,0. The direction is taken only on the start edge, so later changes of `dir_desc` have no effect on a running sequence.
- R5: `code_out` changes only on an edge where `xfer` is high. On that edge all six channels take their stage-one values together.
- R6: When a transfer and a stage-one write share an edge, stage two receives the stage-one value from before that write.
- R7: `seq_done` is high for exactly the one cycle after the sixth word is stored. Words on the bus after that are not stored until the next start.
- R8: When no sequence is running and no start is captured, a captured `direct_en` with `ch_addr` 0 to 5 stores the bus word into that channel only.
- R9: A direct write with `ch_addr` 6 or 7 is ignored, and every stage-one register keeps its value.
- R10: With `edge_fall`=1, `bus_word`, `go_seq`, `direct_en` and `ch_addr` take the values they had at the falling edge before the rising edge that acts. With `edge_fall`=0 they take the values present at that rising edge. `xfer` is always taken on the rising edge.
- R11: A start captured during a running sequence restarts it from the first channel. While a sequence runs, `direct_en` and `ch_addr` are ignored and the word goes to the sequence pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_fall | input | 1 | 1: capture bus and controls at the falling edge; 0: at the rising edge |
| dir_desc | input | 1 | 1: descending sequence order; sampled on the start edge |
| go_seq | input | 1 | Start-sequence pulse |
| direct_en | input | 1 | Direct single-channel write enable |
| ch_addr | input | 3 | Channel address for direct writes |
| bus_word | input | 10 | Shared input data word |
| xfer | input | 1 | Copy stage one into stage two for all channels |
| code_out | output | 60 | Six stage-two codes; channel i at bits 10*i+9 to 10*i |
| seq_done | output | 1 | One-cycle pulse after the sixth sequence word |

## Verification
The bench targets four corner cases:

- **Transfer on a write edge.** A transfer is issued in the middle of a descending fill. A design that forwarded the incoming word would show the new code one transfer early.
- **Direction changed mid-sequence.** `dir_desc` is flipped during a fill. A design that reads the pin live instead of latching it would scatter words across both ends of the bank.
- **Invalid address and ignored controls.** Direct writes to addresses 6 and 7 are issued; an unguarded decoder would alias them onto a real channel. Direct controls are also raised during a fill, and a start is issued mid-sequence, to expose any mixing of the two paths.
- **Falling-edge mode.** In falling-edge mode the bus is scrambled between the falling and rising edges. A design that still sampled at the rising edge would store the decoy word.

// File: rtl/vidcol_loader_pkg.sv
`timescale 1ns/1ps
package vidcol_loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } ld_state_t;
endpackage

// File: rtl/vl_edge_sel.sv
`timescale 1ns/1ps
// Chooses the capture edge for bus word and load controls.
module vl_edge_sel #(
    parameter int W  = 10,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_fall,
    input  logic          go_i,
    input  logic          wen_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  word_i,
    output logic          go_o,
    output logic          wen_o,
    output logic [AW-1:0] addr_o,
    output logic [W-1:0]  word_o
);
    logic          go_n, wen_n;
    logic [AW-1:0] addr_n;
    logic [W-1:0]  word_n;

    // Falling-edge sample; consumed at the next rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_n   <= 1'b0;
            wen_n  <= 1'b0;
            addr_n <= '0;
            word_n <= '0;
        end else begin
            go_n   <= go_i;
            wen_n  <= wen_i;
            addr_n <= addr_i;
            word_n <= word_i;
        end
    end

    assign go_o   = edge_fall ? go_n   : go_i;
    assign wen_o  = edge_fall ? wen_n  : wen_i;
    assign addr_o = edge_fall ? addr_n : addr_i;
    assign word_o = edge_fall ? word_n : word_i;
endmodule

// File: rtl/vl_seq_fsm.sv
`timescale 1ns/1ps
// Load controller: sequence pointer, direction latch, direct-address decode.
module vl_seq_fsm
    import vidcol_loader_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          wen,
    input  logic [AW-1:0] addr,
    input  logic          dir_desc,
    output logic          fill_active,
    output logic          done,
    output logic          wr_en,
    output logic [AW-1:0] wr_sel
);
    localparam logic [AW-1:0] LAST  = AW'(NCH - 1);
    localparam logic [AW:0]   NCH_W = (AW+1)'(NCH);

    ld_state_t     st, st_nx;
    logic [AW-1:0] cnt, cnt_nx;
    logic          dir_q, dir_nx;

    // Next-state logic; a captured start wins in every state (R2, R11).
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        dir_nx = dir_q;
        if (go) begin
            st_nx  = ST_FILL;
            cnt_nx = '0;
            dir_nx = dir_desc;
        end else begin
            unique case (st)
                ST_IDLE: st_nx = ST_IDLE;
                ST_FILL: begin
                    if (cnt == LAST) begin
                        st_nx = ST_DONE;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_DONE: st_nx = ST_IDLE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            dir_q <= 1'b0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            dir_q <= dir_nx;
        end
    end

    // Outputs.
    always_comb begin
        fill_active = 1'b0;
        done        = 1'b0;
        wr_en       = 1'b0;
        wr_sel      = addr;
        unique case (st)
            ST_FILL: begin
                fill_active = 1'b1;
                wr_en       = !go;
                wr_sel      = dir_q ? (LAST - cnt) : cnt;
            end
            ST_DONE: begin
                done  = 1'b1;
                wr_en = wen && !go && ({1'b0, addr} < NCH_W);
            end
            ST_IDLE: begin
                wr_en = wen && !go && ({1'b0, addr} < NCH_W);
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/vl_latch_bank.sv
`timescale 1ns/1ps
// Two-stage register per channel: write-selected stage one, common-transfer stage two.
module vl_latch_bank #(
    parameter int NCH = 6,
    parameter int W   = 10,
    parameter int AW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             xfer,
    output logic [NCH*W-1:0] stg1_flat,
    output logic [NCH*W-1:0] stg2_flat
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [W-1:0] s1, s2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= '0;
            end else if (wr_en && (wr_sel == AW'(i))) begin
                s1 <= wr_data;
            end
        end

        // Nonblocking read of s1 gives the pre-write value on a shared edge.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s2 <= '0;
            end else if (xfer) begin
                s2 <= s1;
            end
        end

        assign stg1_flat[i*W +: W] = s1;
        assign stg2_flat[i*W +: W] = s2;
    end
endmodule

// File: rtl/vidcol_loader.sv
`timescale 1ns/1ps
module vidcol_loader #(
    parameter  int NCH = 6,
    parameter  int W   = 10,
    localparam int AW  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_fall,
    input  logic             dir_desc,
    input  logic             go_seq,
    input  logic             direct_en,
    input  logic [AW-1:0]    ch_addr,
    input  logic [W-1:0]     bus_word,
    input  logic             xfer,
    output logic [NCH*W-1:0] code_out,
    output logic             seq_done
);
    logic          cap_go, cap_wen;
    logic [AW-1:0] cap_addr;
    logic [W-1:0]  cap_word;
    logic          busy, wr_en;
    logic [AW-1:0] wr_sel;
    logic [NCH*W-1:0] stg1;

    vl_edge_sel #(.W(W), .AW(AW)) u_edge (
        .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall),
        .go_i(go_seq), .wen_i(direct_en), .addr_i(ch_addr), .word_i(bus_word),
        .go_o(cap_go), .wen_o(cap_wen), .addr_o(cap_addr), .word_o(cap_word)
    );

    vl_seq_fsm #(.NCH(NCH), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(cap_go), .wen(cap_wen), .addr(cap_addr),
        .dir_desc(dir_desc), .fill_active(busy), .done(seq_done),
        .wr_en(wr_en), .wr_sel(wr_sel)
    );

    vl_latch_bank #(.NCH(NCH), .W(W), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(cap_word), .xfer(xfer), .stg1_flat(stg1), .stg2_flat(code_out)
    );
endmodule

// File: rtl/vidcol_loader_chk.sv
`timescale 1ns/1ps
module vidcol_loader_chk #(
    parameter int NCH = 6,
    parameter int W   = 10,
    parameter int AW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer,
    input logic [NCH*W-1:0] code_out,
    input logic             seq_done,
    input logic [NCH*W-1:0] stg1,
    input logic             cap_go,
    input logic             cap_wen,
    input logic [AW-1:0]    cap_addr,
    input logic             busy
);
    localparam logic [AW:0] NCH_W = (AW+1)'(NCH);

    p_start_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_go |=> $stable(stg1));

    p_hold_without_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code_out));

    p_xfer_old_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (code_out == $past(stg1)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    p_done_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> $past(busy));

    p_bad_addr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wen && ({1'b0, cap_addr} >= NCH_W) && !cap_go && !busy) |=> $stable(stg1));
endmodule

bind vidcol_loader vidcol_loader_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .code_out(code_out),
    .seq_done(seq_done), .stg1(stg1), .cap_go(cap_go), .cap_wen(cap_wen),
    .cap_addr(cap_addr), .busy(busy)
);

// File: tb/tb_vidcol_loader.sv
`timescale 1ns/1ps
module tb_vidcol_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_fall = 1'b0, dir_desc = 1'b0, go_seq = 1'b0;
    logic       direct_en = 1'b0, xfer = 1'b0;
    logic [2:0] ch_addr = '0;
    logic [9:0] bus_word = '0;
    logic [59:0] code_out;
    logic        seq_done;

    int n_run = 0, n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    vidcol_loader dut (
        .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall), .dir_desc(dir_desc),
        .go_seq(go_seq), .direct_en(direct_en), .ch_addr(ch_addr),
        .bus_word(bus_word), .xfer(xfer), .code_out(code_out), .seq_done(seq_done)
    );

    // Behavioural reference model
    logic [9:0] mm [6];
    logic [9:0] ss [6];
    int  m_cnt = 0;
    bit  m_busy = 0, m_dir = 0, m_done = 0;
    bit  sn_go = 0, sn_wen = 0;
    int  sn_addr = 0;
    logic [9:0] sn_word = '0;

    initial for (int k = 0; k < 6; k++) begin mm[k] = '0; ss[k] = '0; end

    always @(negedge clk) begin
        sn_go = go_seq; sn_wen = direct_en; sn_addr = ch_addr; sn_word = bus_word;
    end

    always @(posedge clk) begin
        bit e_go, e_wen; int e_addr; logic [9:0] e_word; int idx;
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin mm[k] = '0; ss[k] = '0; end
            m_cnt = 0; m_busy = 0; m_dir = 0; m_done = 0;
        end else begin
            e_go   = edge_fall ? sn_go   : go_seq;
            e_wen  = edge_fall ? sn_wen  : direct_en;
            e_addr = edge_fall ? sn_addr : int'(ch_addr);
            e_word = edge_fall ? sn_word : bus_word;
            if (xfer) for (int k = 0; k < 6; k++) ss[k] = mm[k];
            if (e_go) begin
                m_busy = 1; m_cnt = 0; m_dir = dir_desc; m_done = 0;
            end else if (m_busy) begin
                idx = m_dir ? 5 - m_cnt : m_cnt;
                mm[idx] = e_word;
                if (m_cnt == 5) begin m_busy = 0; m_done = 1; end
                else m_cnt++;
            end else begin
                m_done = 0;
                if (e_wen && e_addr < 6) mm[e_addr] = e_word;
            end
        end
    end

    function automatic logic [59:0] model_flat();
        logic [59:0] f;
        for (int k = 0; k < 6; k++) f[k*10 +: 10] = ss[k];
        return f;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "code_out", {4'h0, code_out}, {4'h0, model_flat()});
            check(cur_req, "seq_done", {63'h0, seq_done}, {63'h0, m_done});
        end
    end

    task automatic cyc(bit g, bit w, int a, int word, bit x);
        @(posedge clk); #1;
        go_seq = g; direct_en = w; ch_addr = 3'(a); bus_word = 10'(word); xfer = x;
        if (edge_fall) begin
            @(negedge clk); #1;
            bus_word = ~10'(word); // decoy after the falling edge
        end
    endtask

    function automatic logic [9:0] ch(int i);
        return code_out[i*10 +: 10];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset code_out", {4'h0, code_out}, 64'h0);
        check("R1", "reset seq_done", {63'h0, seq_done}, 64'h0);

        // Ascending fill
        cur_req = "R2"; cyc(1, 0, 0, 999, 0);
        cur_req = "R3";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 100 + i, 0);
        cur_req = "R7"; cyc(0, 0, 0, 7, 0);
        @(negedge clk); check("R7", "done pulse", {63'h0, seq_done}, 64'h1);
        cyc(0, 0, 0, 8, 0);
        @(negedge clk); check("R7", "done low", {63'h0, seq_done}, 64'h0);
        cur_req = "R5"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check("R3", "ch0", {54'h0, ch(0)}, 64'd100);
        check("R3", "ch5", {54'h0, ch(5)}, 64'd105);
        check("R2", "ch1 not start word", {54'h0, ch(1)}, 64'd101);

        // Descending fill, direction flipped mid-run, transfer mid-run
        cur_req = "R4"; dir_desc = 1'b1; cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            if (i == 1) dir_desc = 1'b0;
            cur_req = (i == 2) ? "R6" : "R4";
            cyc(0, 0, 0, 200 + i, i == 2);
            if (i == 3) begin
                @(negedge clk);
                check("R6", "ch3 pre-write", {54'h0, ch(3)}, 64'd103);
                check("R6", "ch5 new", {54'h0, ch(5)}, 64'd200);
            end
        end
        cur_req = "R5"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check("R4", "ch5", {54'h0, ch(5)}, 64'd200);
        check("R4", "ch0", {54'h0, ch(0)}, 64'd205);

        // Direct writes, valid and invalid
        cur_req = "R8"; cyc(0, 1, 2, 555, 0);
        cur_req = "R9"; cyc(0, 1, 6, 1, 0); cyc(0, 1, 7, 2, 0);
        cur_req = "R5"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check("R8", "ch2 direct", {54'h0, ch(2)}, 64'd555);
        check("R9", "ch0 kept", {54'h0, ch(0)}, 64'd205);
        check("R9", "ch1 kept", {54'h0, ch(1)}, 64'd204);

        // Restart and direct controls during a running sequence
        cur_req = "R11"; cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 300, 0); cyc(0, 0, 0, 301, 0);
        cyc(0, 1, 4, 777, 0);
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 400 + i, 0);
        cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check("R11", "ch2 restarted", {54'h0, ch(2)}, 64'd402);
        check("R11", "ch4 not direct", {54'h0, ch(4)}, 64'd404);

        // Falling-edge capture
        cur_req = "R10"; edge_fall = 1'b1; dir_desc = 1'b1;
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 500 + i, 0);
        cyc(0, 1, 1, 42, 0);
        cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check("R10", "ch5 falling", {54'h0, ch(5)}, 64'd500);
        check("R10", "ch1 falling direct", {54'h0, ch(1)}, 64'd42);
        repeat (2) @(posedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule